// File: doc/BRIEF.md
# Integer ALU with Shifter

A combinational 32-bit arithmetic and logic unit meant for the execute stage of a load/store RISC core. Each cycle it takes two operands, a 5-bit constant shift amount and a 5-bit operation code, and returns a result together with a zero indication and a signed-overflow indication. It has no clock and no state. The surrounding pipeline registers its inputs and outputs.

The unit covers several operation groups:

- add and subtract, each in a variant that reports overflow and a variant that wraps silently;
- the four bitwise operations;
- immediate forms, which take operand B's low 16 bits and widen them by sign or by zeros;
- placing a 16-bit constant in the upper half-word;
- signed and unsigned compare-to-flag;
- three shift kinds, with the amount taken from the constant field or from operand A.

Whether the overflow indication raises a trap is up to the caller.

Top module: `alu_core`

## Requirements
- R1: Op 0 gives A+B and op 2 gives A-B, both modulo 2^32. For these two ops `ovf_flag` is 1 exactly when A and the effective second operand (B, or its inverse for subtract) have the same sign and the result's sign differs from it.
- R2: Op 1 (add) and op 3 (subtract) give the same results as ops 0 and 2, but `ovf_flag` is always 0.
- R3: Op 4 gives A AND B, op 5 gives A OR B, op 6 gives A XOR B, and op 7 gives NOT(A OR B).
- R4: Op 8 adds A to B[15:0] sign-extended to 32 bits, with overflow reported as in R1. Op 9 does the same sum with `ovf_flag` held at 0. B[31:16] has no effect on either op.
- R5: Ops 10, 11 and 12 give AND, OR and XOR of A with B[15:0] zero-extended to 32 bits.
- R6: Op 13 gives B[15:0] in bits 31..16 and zeros in bits 15..0.
- R7: Op 14 gives 1 when A < B in two's-complement order, else 0. Op 15 gives 1 when A < B as unsigned numbers, else 0.
- R8: Op 16 is the signed compare of R7 and op 17 is the unsigned compare of R7, both against B[15:0] sign-extended to 32 bits.
- R9: Ops 18, 19 and 20 shift B by `shamt`: 18 shifts left logical, 19 shifts right logical, and 20 shifts right arithmetic, replicating B[31].
- R10: Ops 21, 22 and 23 are the same three shifts of B, with the amount taken from A[4:0]. A[31:5] and `shamt` have no effect on them.
- R11: `zero_flag` is 1 exactly when `result` is 0.
- R12: Op codes 24 to 31 give a result of 0 and `ovf_flag` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code (see requirements) |
| opnd_a | input | 32 | First operand; also the variable shift amount |
| opnd_b | input | 32 | Second operand; low half is the immediate |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | Result equals zero |
| ovf_flag | output | 1 | Signed overflow of a reporting add/subtract |

## Verification
The bench aims at the signed boundaries: the largest positive value plus one, and the most negative value minus one. A design that mixed up the carry with signed overflow, or that raised the flag for the wrapping variants, fails there.

Compares between -1 and +1, and between the most negative and the largest positive value, expose a signed compare that reads the raw difference sign, or an unsigned compare that uses signed order.

Shift sweeps over every amount, with garbage in A's upper bits and in `shamt`, catch:
- a lost sign fill;
- a barrel stage wired to the wrong distance;
- a variable shift that reads the wrong field.

Immediates with bit 15 set, and garbage in B's upper half, catch sign and zero extension that are swapped or applied to the wrong ops.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_CHK   = 5'd0,
        OP_ADD_WRAP  = 5'd1,
        OP_SUB_CHK   = 5'd2,
        OP_SUB_WRAP  = 5'd3,
        OP_AND       = 5'd4,
        OP_OR        = 5'd5,
        OP_XOR       = 5'd6,
        OP_NOR       = 5'd7,
        OP_ADDI_CHK  = 5'd8,
        OP_ADDI_WRAP = 5'd9,
        OP_ANDI      = 5'd10,
        OP_ORI       = 5'd11,
        OP_XORI      = 5'd12,
        OP_UPPER     = 5'd13,
        OP_LT_S      = 5'd14,
        OP_LT_U      = 5'd15,
        OP_LTI_S     = 5'd16,
        OP_LTI_U     = 5'd17,
        OP_SHL_K     = 5'd18,
        OP_SHR_K     = 5'd19,
        OP_SHA_K     = 5'd20,
        OP_SHL_V     = 5'd21,
        OP_SHR_V     = 5'd22,
        OP_SHA_V     = 5'd23
    } alu_op_e;

    typedef enum logic [1:0] {
        BSRC_RAW,
        BSRC_SEXT,
        BSRC_ZEXT,
        BSRC_HIGH
    } bsrc_e;

    typedef enum logic [1:0] {
        BIT_AND,
        BIT_OR,
        BIT_XOR,
        BIT_NOR
    } bitop_e;

    typedef enum logic [1:0] {
        SH_LEFT,
        SH_RLOG,
        SH_RARITH
    } shkind_e;

    typedef enum logic [2:0] {
        GRP_ARITH,
        GRP_BITS,
        GRP_PASS,
        GRP_LT_S,
        GRP_LT_U,
        GRP_SHIFT,
        GRP_NONE
    } grp_e;

    typedef struct packed {
        grp_e    grp;
        bsrc_e   bsrc;
        logic    sub;
        logic    trap;
        bitop_e  bop;
        shkind_e shk;
        logic    var_amt;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_core_pkg::*;
(
    input  logic [OP_W-1:0] op_sel,
    output alu_ctrl_t       ctrl
);

    always_comb begin
        ctrl         = '0;
        ctrl.grp     = GRP_NONE;
        ctrl.bsrc    = BSRC_RAW;
        ctrl.bop     = BIT_AND;
        ctrl.shk     = SH_LEFT;
        unique case (alu_op_e'(op_sel))
            OP_ADD_CHK:   begin ctrl.grp = GRP_ARITH; ctrl.trap = 1'b1; end
            OP_ADD_WRAP:  begin ctrl.grp = GRP_ARITH; end
            OP_SUB_CHK:   begin ctrl.grp = GRP_ARITH; ctrl.sub = 1'b1; ctrl.trap = 1'b1; end
            OP_SUB_WRAP:  begin ctrl.grp = GRP_ARITH; ctrl.sub = 1'b1; end
            OP_AND:       begin ctrl.grp = GRP_BITS;  ctrl.bop = BIT_AND; end
            OP_OR:        begin ctrl.grp = GRP_BITS;  ctrl.bop = BIT_OR;  end
            OP_XOR:       begin ctrl.grp = GRP_BITS;  ctrl.bop = BIT_XOR; end
            OP_NOR:       begin ctrl.grp = GRP_BITS;  ctrl.bop = BIT_NOR; end
            OP_ADDI_CHK:  begin ctrl.grp = GRP_ARITH; ctrl.bsrc = BSRC_SEXT; ctrl.trap = 1'b1; end
            OP_ADDI_WRAP: begin ctrl.grp = GRP_ARITH; ctrl.bsrc = BSRC_SEXT; end
            OP_ANDI:      begin ctrl.grp = GRP_BITS;  ctrl.bsrc = BSRC_ZEXT; ctrl.bop = BIT_AND; end
            OP_ORI:       begin ctrl.grp = GRP_BITS;  ctrl.bsrc = BSRC_ZEXT; ctrl.bop = BIT_OR;  end
            OP_XORI:      begin ctrl.grp = GRP_BITS;  ctrl.bsrc = BSRC_ZEXT; ctrl.bop = BIT_XOR; end
            OP_UPPER:     begin ctrl.grp = GRP_PASS;  ctrl.bsrc = BSRC_HIGH; end
            OP_LT_S:      begin ctrl.grp = GRP_LT_S;  ctrl.sub = 1'b1; end
            OP_LT_U:      begin ctrl.grp = GRP_LT_U;  ctrl.sub = 1'b1; end
            OP_LTI_S:     begin ctrl.grp = GRP_LT_S;  ctrl.sub = 1'b1; ctrl.bsrc = BSRC_SEXT; end
            OP_LTI_U:     begin ctrl.grp = GRP_LT_U;  ctrl.sub = 1'b1; ctrl.bsrc = BSRC_SEXT; end
            OP_SHL_K:     begin ctrl.grp = GRP_SHIFT; ctrl.shk = SH_LEFT;   end
            OP_SHR_K:     begin ctrl.grp = GRP_SHIFT; ctrl.shk = SH_RLOG;   end
            OP_SHA_K:     begin ctrl.grp = GRP_SHIFT; ctrl.shk = SH_RARITH; end
            OP_SHL_V:     begin ctrl.grp = GRP_SHIFT; ctrl.shk = SH_LEFT;   ctrl.var_amt = 1'b1; end
            OP_SHR_V:     begin ctrl.grp = GRP_SHIFT; ctrl.shk = SH_RLOG;   ctrl.var_amt = 1'b1; end
            OP_SHA_V:     begin ctrl.grp = GRP_SHIFT; ctrl.shk = SH_RARITH; ctrl.var_amt = 1'b1; end
            default:      begin ctrl.grp = GRP_NONE; end
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf,
    output logic             lt_s,
    output logic             lt_u
);

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    assign b_eff = b ^ {WIDTH{sub}};
    assign wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    assign sum   = wide[WIDTH-1:0];
    assign ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    assign lt_u  = ~wide[WIDTH];
    assign lt_s  = sum[WIDTH-1] ^ ovf;

    // Compare outputs against the language's own ordering.
    always_comb begin
        if (sub && !$isunknown({a, b})) begin
            assert_unsigned_order_R7: assert (lt_u == (a < b))
                else $error("unsigned compare disagrees with natural order");
            assert_signed_order_R7: assert (lt_s == ($signed(a) < $signed(b)))
                else $error("signed compare disagrees with two's-complement order");
        end
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_core_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   amt,
    input  shkind_e          kind,
    output logic [WIDTH-1:0] dout
);

    logic             fill;
    logic [WIDTH-1:0] stage [SHW+1];

    assign fill     = (kind == SH_RARITH) ? din[WIDTH-1] : 1'b0;
    assign stage[0] = din;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int DIST = 2 ** i;
        logic [WIDTH-1:0] moved;
        assign moved = (kind == SH_LEFT)
                     ? {stage[i][WIDTH-1-DIST:0], {DIST{1'b0}}}
                     : {{DIST{fill}}, stage[i][WIDTH-1:DIST]};
        assign stage[i+1] = amt[i] ? moved : stage[i];
    end

    assign dout = stage[SHW];

    always_comb begin
        if (!$isunknown({din, amt})) begin
            assert_zero_amount_R9: assert ((amt != '0) || (dout == din))
                else $error("shift by zero changed the value");
            assert_sign_fill_R9: assert (!(kind == SH_RARITH && din[WIDTH-1]) || dout[WIDTH-1])
                else $error("arithmetic right shift lost the sign");
        end
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_core_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  bitop_e           bop,
    output logic [WIDTH-1:0] y
);

    always_comb begin
        unique case (bop)
            BIT_AND: y = a & b;
            BIT_OR:  y = a | b;
            BIT_XOR: y = a ^ b;
            BIT_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_core_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int IMM_W  = 16,
    localparam int SHW   = $clog2(WIDTH)
) (
    input  logic [OP_W-1:0]  op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [SHW-1:0]   shamt,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag
);

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] b_sel;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] bits_y;
    logic [WIDTH-1:0] shift_y;
    logic [SHW-1:0]   sh_amt;
    logic             ovf_raw;
    logic             lt_s;
    logic             lt_u;

    alu_decode u_decode (
        .op_sel (op_sel),
        .ctrl   (ctrl)
    );

    // Second-operand source: raw, widened immediate, or upper half-word.
    always_comb begin
        unique case (ctrl.bsrc)
            BSRC_RAW:  b_sel = opnd_b;
            BSRC_SEXT: b_sel = {{(WIDTH-IMM_W){opnd_b[IMM_W-1]}}, opnd_b[IMM_W-1:0]};
            BSRC_ZEXT: b_sel = {{(WIDTH-IMM_W){1'b0}}, opnd_b[IMM_W-1:0]};
            BSRC_HIGH: b_sel = {opnd_b[IMM_W-1:0], {(WIDTH-IMM_W){1'b0}}};
            default:   b_sel = opnd_b;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a    (opnd_a),
        .b    (b_sel),
        .sub  (ctrl.sub),
        .sum  (sum),
        .ovf  (ovf_raw),
        .lt_s (lt_s),
        .lt_u (lt_u)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a   (opnd_a),
        .b   (b_sel),
        .bop (ctrl.bop),
        .y   (bits_y)
    );

    assign sh_amt = ctrl.var_amt ? opnd_a[SHW-1:0] : shamt;

    alu_shifter #(.WIDTH(WIDTH)) u_shifter (
        .din  (opnd_b),
        .amt  (sh_amt),
        .kind (ctrl.shk),
        .dout (shift_y)
    );

    always_comb begin
        unique case (ctrl.grp)
            GRP_ARITH: result = sum;
            GRP_BITS:  result = bits_y;
            GRP_PASS:  result = b_sel;
            GRP_LT_S:  result = {{(WIDTH-1){1'b0}}, lt_s};
            GRP_LT_U:  result = {{(WIDTH-1){1'b0}}, lt_u};
            GRP_SHIFT: result = shift_y;
            default:   result = '0;
        endcase
    end

    assign ovf_flag  = ctrl.trap && (ctrl.grp == GRP_ARITH) && ovf_raw;
    assign zero_flag = (result == '0);

    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b, shamt})) begin
            assert_no_overflow_R2: assert (!ovf_flag || op_sel == 5'd0 || op_sel == 5'd2 || op_sel == 5'd8)
                else $error("overflow raised by a non-reporting operation");
            assert_flag_width_R7: assert (!(op_sel >= 5'd14 && op_sel <= 5'd17) || $countones(result[WIDTH-1:1]) == 0)
                else $error("compare result wider than one bit");
            assert_upper_clear_R6: assert (op_sel != 5'd13 || result[WIDTH-IMM_W-1:0] == '0)
                else $error("upper-constant op left low bits set");
            assert_unused_quiet_R12: assert (op_sel < 5'd24 || (result == '0 && !ovf_flag))
                else $error("unused op code produced output");
            assert_zero_flag_R11: assert (zero_flag == ($countones(result) == 0))
                else $error("zero flag disagrees with result");
        end
    end

endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb_top;

    localparam int NV     = 37;
    localparam int WD_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        zero_flag;
    logic        ovf_flag;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    alu_core dut_i (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .shamt     (shamt),
        .result    (result),
        .zero_flag (zero_flag),
        .ovf_flag  (ovf_flag)
    );

    // {req[110:107], op[106:102], a[101:70], b[69:38], sh[37:33], res[32:1], ovf[0]}
    localparam logic [110:0] VEC [NV] = '{
        {4'd1,  5'd0,  32'h00000005, 32'h00000007, 5'd0,  32'h0000000C, 1'b0}, // R1
        {4'd1,  5'd0,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b1}, // R1
        {4'd1,  5'd2,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b1}, // R1
        {4'd1,  5'd2,  32'h00000003, 32'h00000005, 5'd0,  32'hFFFFFFFE, 1'b0}, // R1
        {4'd1,  5'd2,  32'h00000000, 32'h80000000, 5'd0,  32'h80000000, 1'b1}, // R1
        {4'd2,  5'd1,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b0}, // R2
        {4'd2,  5'd3,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b0}, // R2
        {4'd3,  5'd4,  32'hF0F0F0F0, 32'h0FF00FF0, 5'd0,  32'h00F000F0, 1'b0}, // R3
        {4'd3,  5'd5,  32'hF0F0F0F0, 32'h0FF00FF0, 5'd0,  32'hFFF0FFF0, 1'b0}, // R3
        {4'd3,  5'd6,  32'hF0F0F0F0, 32'h0FF00FF0, 5'd0,  32'hFF00FF00, 1'b0}, // R3
        {4'd3,  5'd7,  32'hF0F0F0F0, 32'h0FF00FF0, 5'd0,  32'h000F000F, 1'b0}, // R3
        {4'd4,  5'd8,  32'h000000C8, 32'hABCDFF9C, 5'd0,  32'h00000064, 1'b0}, // R4
        {4'd4,  5'd8,  32'h80000000, 32'h0000FFFF, 5'd0,  32'h7FFFFFFF, 1'b1}, // R4
        {4'd4,  5'd9,  32'h80000000, 32'h0000FFFF, 5'd0,  32'h7FFFFFFF, 1'b0}, // R4
        {4'd5,  5'd10, 32'hFFFFFFFF, 32'hFFFF8001, 5'd0,  32'h00008001, 1'b0}, // R5
        {4'd5,  5'd11, 32'h12340000, 32'hFFFF8001, 5'd0,  32'h12348001, 1'b0}, // R5
        {4'd5,  5'd12, 32'hFFFFFFFF, 32'h0000FFFF, 5'd0,  32'hFFFF0000, 1'b0}, // R5
        {4'd6,  5'd13, 32'h55555555, 32'hDEAD1234, 5'd7,  32'h12340000, 1'b0}, // R6
        {4'd7,  5'd14, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000001, 1'b0}, // R7
        {4'd7,  5'd15, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b0}, // R7
        {4'd7,  5'd14, 32'h00000002, 32'h00000001, 5'd0,  32'h00000000, 1'b0}, // R7
        {4'd7,  5'd15, 32'h00000001, 32'hFFFFFFFF, 5'd0,  32'h00000001, 1'b0}, // R7
        {4'd7,  5'd14, 32'h80000000, 32'h7FFFFFFF, 5'd0,  32'h00000001, 1'b0}, // R7
        {4'd8,  5'd16, 32'hFFFFFF00, 32'h0000FF9C, 5'd0,  32'h00000001, 1'b0}, // R8
        {4'd8,  5'd17, 32'hFFFFFF00, 32'h0000FF9C, 5'd0,  32'h00000001, 1'b0}, // R8
        {4'd8,  5'd17, 32'h00001000, 32'h00008000, 5'd0,  32'h00000001, 1'b0}, // R8
        {4'd8,  5'd16, 32'h00001000, 32'h00008000, 5'd0,  32'h00000000, 1'b0}, // R8
        {4'd9,  5'd18, 32'h00000000, 32'h00000001, 5'd31, 32'h80000000, 1'b0}, // R9
        {4'd9,  5'd19, 32'h00000000, 32'h80000000, 5'd31, 32'h00000001, 1'b0}, // R9
        {4'd9,  5'd20, 32'h00000000, 32'h80000000, 5'd4,  32'hF8000000, 1'b0}, // R9
        {4'd9,  5'd20, 32'h00000000, 32'h40000000, 5'd4,  32'h04000000, 1'b0}, // R9
        {4'd9,  5'd19, 32'h0000001F, 32'hDEADBEEF, 5'd0,  32'hDEADBEEF, 1'b0}, // R9
        {4'd10, 5'd21, 32'h00000024, 32'h00000001, 5'd31, 32'h00000010, 1'b0}, // R10
        {4'd10, 5'd22, 32'hFFFFFFE8, 32'hF0000000, 5'd3,  32'h00F00000, 1'b0}, // R10
        {4'd10, 5'd23, 32'h0000001F, 32'h80000000, 5'd0,  32'hFFFFFFFF, 1'b0}, // R10
        {4'd11, 5'd0,  32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b0}, // R11
        {4'd12, 5'd24, 32'h00000005, 32'h00000005, 5'd3,  32'h00000000, 1'b0}  // R12
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] sh);
        @(posedge clk);
        #1;
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        shamt  = sh;
        @(negedge clk);
    endtask

    task automatic run_and_check(input string tag, input logic [4:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic [4:0] sh,
                                 input logic [31:0] exp_res, input logic exp_ovf);
        apply(op, a, b, sh);
        check({tag, " result"}, result, exp_res);
        check({tag, " ovf"}, {31'd0, ovf_flag}, {31'd0, exp_ovf});
        check({tag, " zero"}, {31'd0, zero_flag}, {31'd0, (exp_res == 32'd0)});
    endtask

    initial begin
        #(WD_CYC * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle inputs (all zero, op 0): R11 zero indication on a zero sum
        @(negedge clk);
        check("R11 idle result", result, 32'd0);
        check("R11 idle zero", {31'd0, zero_flag}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            run_and_check($sformatf("R%0d vec%0d", VEC[i][110:107], i),
                          VEC[i][106:102], VEC[i][101:70], VEC[i][69:38],
                          VEC[i][37:33], VEC[i][32:1], VEC[i][0]);
        end

        // R9: arithmetic right shift sweep over every constant amount
        for (int k = 0; k < 32; k++) begin
            run_and_check($sformatf("R9 sra k=%0d", k), 5'd20, 32'hA5A5A5A5,
                          32'h80000000, 5'(k), ~(32'h7FFFFFFF >> k), 1'b0);
        end

        // R10: variable left shift, with upper bits of A and shamt set as noise
        for (int k = 0; k < 32; k++) begin
            run_and_check($sformatf("R10 sllv k=%0d", k), 5'd21, 32'hFFFFFFE0 | 32'(k),
                          32'h00000001, ~5'(k), 32'h00000001 << k, 1'b0);
        end

        // R9: logical right shift sweep
        for (int k = 0; k < 32; k++) begin
            run_and_check($sformatf("R9 srl k=%0d", k), 5'd19, 32'h0,
                          32'hFFFFFFFF, 5'(k), 32'hFFFFFFFF >> k, 1'b0);
        end

        // R11: equal operands subtract to zero
        run_and_check("R11 sub equal", 5'd2, 32'h12345678, 32'h12345678, 5'd0, 32'd0, 1'b0);

        // R12: the highest unused code
        run_and_check("R12 op31", 5'd31, 32'hFFFFFFFF, 32'h7FFFFFFF, 5'd31, 32'd0, 1'b0);

        // R2: wrapping subtract of most negative minus one keeps the flag low
        run_and_check("R2 subu edge", 5'd3, 32'h80000000, 32'h00000001, 5'd0, 32'h7FFFFFFF, 1'b0);

        // R4: upper half of B has no effect on the sign-extended add
        run_and_check("R4 addiu noise", 5'd9, 32'h00000010, 32'h7777FFFF, 5'd0, 32'h0000000F, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule